// File: doc/BRIEF.md
# Paired Register Bank for an 8-bit Processor

This block stores the working registers of a small 8-bit processor: seven byte registers (an accumulator and six general registers) plus a 16-bit stack pointer. The six general registers also combine into three 16-bit pairs. Byte accesses use a 3-bit register code, with a configurable number of combinational read ports and one synchronous write port. Pair accesses use a 2-bit pair code. Each pair access is a combinational read, a synchronous load, or a synchronous step by plus or minus one.

The block also has an address port for the memory sequencer. It returns one of the three pairs as a bus address. For the two "walking pointer" selections, it returns the address pair's value before the update, and it adds or subtracts one in the same clock. One byte code does not name a register. It stands for "the byte in memory at the address pair", so the bank asserts a per-port flag and leaves that transfer to the external sequencer.

Top module: `cpu_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears every byte register and the stack pointer to zero. After reset, every byte read and every pair read returns zero.
- R2: The byte codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L and 7=A. A byte write with `wr_en` takes effect at the next clock edge. Every read port returns the selected register combinationally.
- R3: Byte code 6 means "memory at HL". A read port given code 6 raises its `rd_mem` bit and returns 0x00. A write with code 6 raises `wr_mem` and changes no register.
- R4: The pair codes are 0=BC, 1=DE, 2=HL and 3=SP. `pr_data` returns the high register times 256 plus the low register, or the whole stack pointer.
- R5: A pair load (`pw_en`) places bits 15:8 in the high register and bits 7:0 in the low register. For code 3 it loads all 16 bits of the stack pointer.
- R6: A step (`step_en`) adds one to the selected pair, or subtracts one when `step_dec` is 1. Carries and borrows cross between the two bytes, and the result wraps modulo 65536.
- R7: The pointer codes are 0=BC, 1=DE, 2=HL then add one, and 3=HL then subtract one. `ptr_addr` shows the value before the update. With `ptr_en`, codes 2 and 3 write the updated HL at the clock edge. Codes 0 and 1 change nothing.
- R8: The pointer update of HL wraps at 16 bits: 0xFFFF steps up to 0x0000, and 0x0000 steps down to 0xFFFF.
- R9: Suppose a byte write to H or L (codes 4 and 5) coincides with an HL pointer update. Then the pointer result is stored and `wr_lost` is high in that cycle. A byte write to any other register in the same cycle is stored, and `wr_lost` stays low.
- R10: When several writers target one register in the same cycle, the order of priority is: pointer update, then pair load, then step, then byte write. A pair operation replaces both bytes of its pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | NUM_RD×3 | Byte code for each read port |
| rd_data | output | NUM_RD×8 | Byte read data for each port |
| rd_mem | output | NUM_RD | Port selected the memory-at-HL code |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Byte write code |
| wr_data | input | 8 | Byte write data |
| wr_mem | output | 1 | Byte write selected the memory-at-HL code |
| pr_sel | input | 2 | Pair read code |
| pr_data | output | 16 | Pair read value |
| pw_en | input | 1 | Pair load enable |
| pw_sel | input | 2 | Pair load code |
| pw_data | input | 16 | Pair load value |
| step_en | input | 1 | Pair step enable |
| step_sel | input | 2 | Pair step code |
| step_dec | input | 1 | 1 subtracts one, 0 adds one |
| ptr_en | input | 1 | Pointer access enable (allows the HL update) |
| ptr_sel | input | 2 | Pointer code |
| ptr_addr | output | 16 | Pointer address before update |
| wr_lost | output | 1 | Byte write to H/L dropped in favour of the pointer update |

## Verification
The bench targets carries and borrows that must cross from the low byte into the high byte, and the wrap at 0xFFFF/0x0000. A design that stepped only one byte would show the wrong high byte. The pointer port is sampled before the edge and again after it: a design that returned the updated HL as the address would be off by one. The bench also writes code 6 and then reads back every register, to catch a design that wrote code 6 into some real register. Collision cycles check the priority order and the `wr_lost` flag: a wrong order would leave the byte-write value in H or L.

// File: rtl/cpu_regbank_pkg.sv
package cpu_regbank_pkg;

    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int CODE_W = 3;
    localparam int PSEL_W = 2;

    typedef enum logic [CODE_W-1:0] {
        RC_B   = 3'd0,
        RC_C   = 3'd1,
        RC_D   = 3'd2,
        RC_E   = 3'd3,
        RC_H   = 3'd4,
        RC_L   = 3'd5,
        RC_MEM = 3'd6,
        RC_A   = 3'd7
    } reg_code_e;

    typedef enum logic [PSEL_W-1:0] {
        PC_BC = 2'd0,
        PC_DE = 2'd1,
        PC_HL = 2'd2,
        PC_SP = 2'd3
    } pair_code_e;

    typedef enum logic [PSEL_W-1:0] {
        PT_BC  = 2'd0,
        PT_DE  = 2'd1,
        PT_HLI = 2'd2,
        PT_HLD = 2'd3
    } ptr_code_e;

    typedef struct packed {
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] c;
        logic [BYTE_W-1:0] d;
        logic [BYTE_W-1:0] e;
        logic [BYTE_W-1:0] h;
        logic [BYTE_W-1:0] l;
        logic [PAIR_W-1:0] sp;
    } regs_t;

    function automatic logic [PAIR_W-1:0] pair_get(regs_t r, pair_code_e p);
        logic [PAIR_W-1:0] v;
        case (p)
            PC_BC:   v = {r.b, r.c};
            PC_DE:   v = {r.d, r.e};
            PC_HL:   v = {r.h, r.l};
            default: v = r.sp;
        endcase
        return v;
    endfunction

    function automatic regs_t pair_put(regs_t r, pair_code_e p, logic [PAIR_W-1:0] v);
        regs_t o;
        o = r;
        case (p)
            PC_BC:   begin o.b = v[PAIR_W-1:BYTE_W]; o.c = v[BYTE_W-1:0]; end
            PC_DE:   begin o.d = v[PAIR_W-1:BYTE_W]; o.e = v[BYTE_W-1:0]; end
            PC_HL:   begin o.h = v[PAIR_W-1:BYTE_W]; o.l = v[BYTE_W-1:0]; end
            default: o.sp = v;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/cpu_regbank_rdport.sv
module cpu_regbank_rdport
    import cpu_regbank_pkg::*;
(
    input  regs_t                   regs,
    input  logic [CODE_W-1:0]       sel,
    output logic [BYTE_W-1:0]       data,
    output logic                    is_mem
);

    always_comb begin
        data   = '0;
        is_mem = 1'b0;
        case (reg_code_e'(sel))
            RC_B:    data = regs.b;
            RC_C:    data = regs.c;
            RC_D:    data = regs.d;
            RC_E:    data = regs.e;
            RC_H:    data = regs.h;
            RC_L:    data = regs.l;
            RC_A:    data = regs.a;
            default: is_mem = 1'b1;
        endcase
    end

endmodule

// File: rtl/cpu_regbank_step.sv
module cpu_regbank_step
    import cpu_regbank_pkg::*;
(
    input  regs_t                   regs,
    input  logic [PSEL_W-1:0]       sel,
    input  logic                    dec,
    output logic [PAIR_W-1:0]       value
);

    logic [PAIR_W-1:0] cur;

    always_comb begin
        cur   = pair_get(regs, pair_code_e'(sel));
        value = dec ? (cur - PAIR_W'(1)) : (cur + PAIR_W'(1));
    end

endmodule

// File: rtl/cpu_regbank_ptr.sv
module cpu_regbank_ptr
    import cpu_regbank_pkg::*;
(
    input  regs_t                   regs,
    input  logic                    en,
    input  logic [PSEL_W-1:0]       sel,
    output logic [PAIR_W-1:0]       addr,
    output logic                    hl_we,
    output logic [PAIR_W-1:0]       hl_next
);

    logic [PAIR_W-1:0] hl_cur;

    always_comb begin
        hl_cur  = {regs.h, regs.l};
        addr    = hl_cur;
        hl_next = hl_cur;
        hl_we   = 1'b0;
        case (ptr_code_e'(sel))
            PT_BC:  addr = {regs.b, regs.c};
            PT_DE:  addr = {regs.d, regs.e};
            PT_HLI: begin
                hl_next = hl_cur + PAIR_W'(1);
                hl_we   = en;
            end
            default: begin
                hl_next = hl_cur - PAIR_W'(1);
                hl_we   = en;
            end
        endcase
    end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import cpu_regbank_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_RD-1:0][CODE_W-1:0]   rd_sel,
    output logic [NUM_RD-1:0][BYTE_W-1:0]   rd_data,
    output logic [NUM_RD-1:0]               rd_mem,
    input  logic                            wr_en,
    input  logic [CODE_W-1:0]               wr_sel,
    input  logic [BYTE_W-1:0]               wr_data,
    output logic                            wr_mem,
    input  logic [PSEL_W-1:0]               pr_sel,
    output logic [PAIR_W-1:0]               pr_data,
    input  logic                            pw_en,
    input  logic [PSEL_W-1:0]               pw_sel,
    input  logic [PAIR_W-1:0]               pw_data,
    input  logic                            step_en,
    input  logic [PSEL_W-1:0]               step_sel,
    input  logic                            step_dec,
    input  logic                            ptr_en,
    input  logic [PSEL_W-1:0]               ptr_sel,
    output logic [PAIR_W-1:0]               ptr_addr,
    output logic                            wr_lost
);

    regs_t             regs_q;
    regs_t             regs_d;
    logic [PAIR_W-1:0] step_val;
    logic              hl_we;
    logic [PAIR_W-1:0] hl_next;
    logic              wr_hits_hl;

    // read ports, one instance per port
    for (genvar gi = 0; gi < NUM_RD; gi++) begin : g_rd
        cpu_regbank_rdport u_rd (
            .regs   (regs_q),
            .sel    (rd_sel[gi]),
            .data   (rd_data[gi]),
            .is_mem (rd_mem[gi])
        );
    end

    cpu_regbank_step u_step (
        .regs  (regs_q),
        .sel   (step_sel),
        .dec   (step_dec),
        .value (step_val)
    );

    cpu_regbank_ptr u_ptr (
        .regs    (regs_q),
        .en      (ptr_en),
        .sel     (ptr_sel),
        .addr    (ptr_addr),
        .hl_we   (hl_we),
        .hl_next (hl_next)
    );

    always_comb begin
        pr_data    = pair_get(regs_q, pair_code_e'(pr_sel));
        wr_mem     = wr_en && (reg_code_e'(wr_sel) == RC_MEM);
        wr_hits_hl = wr_en && ((reg_code_e'(wr_sel) == RC_H) || (reg_code_e'(wr_sel) == RC_L));
        wr_lost    = wr_hits_hl && hl_we;
    end

    // next state: lowest priority first, later writers override
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_code_e'(wr_sel))
                RC_B:    regs_d.b = wr_data;
                RC_C:    regs_d.c = wr_data;
                RC_D:    regs_d.d = wr_data;
                RC_E:    regs_d.e = wr_data;
                RC_H:    regs_d.h = wr_data;
                RC_L:    regs_d.l = wr_data;
                RC_A:    regs_d.a = wr_data;
                default: ;
            endcase
        end
        if (step_en) begin
            regs_d = pair_put(regs_d, pair_code_e'(step_sel), step_val);
        end
        if (pw_en) begin
            regs_d = pair_put(regs_d, pair_code_e'(pw_sel), pw_data);
        end
        if (hl_we) begin
            regs_d.h = hl_next[PAIR_W-1:BYTE_W];
            regs_d.l = hl_next[BYTE_W-1:0];
        end
        if (rst) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    AST_MEM_CODE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_mem && !pw_en && !step_en && !ptr_en) |=> (regs_q == $past(regs_q))); // R3

    AST_PTR_POST_INC: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && ptr_sel == 2'd2) |=> ({regs_q.h, regs_q.l} == $past(ptr_addr) + 16'd1)); // R7

    AST_PTR_POST_DEC: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && ptr_sel == 2'd3) |=> ({regs_q.h, regs_q.l} == $past(ptr_addr) - 16'd1)); // R8

    AST_SP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pw_en && pw_sel == 2'd3) |=> (regs_q.sp == $past(pw_data))); // R5

    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_sel == 2'd3 && !(pw_en && pw_sel == 2'd3))
        |=> (regs_q.sp == ($past(step_dec) ? $past(regs_q.sp) - 16'd1 : $past(regs_q.sp) + 16'd1))); // R6

    AST_LOST_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        wr_lost |=> ({regs_q.h, regs_q.l} != $past(ptr_addr))); // R9

endmodule

// File: tb/cpu_regbank_test.sv
`timescale 1ns/1ps
module cpu_regbank_test;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0][2:0]  rd_sel;
    logic [1:0][7:0]  rd_data;
    logic [1:0]       rd_mem;
    logic             wr_en;
    logic [2:0]       wr_sel;
    logic [7:0]       wr_data;
    logic             wr_mem;
    logic [1:0]       pr_sel;
    logic [15:0]      pr_data;
    logic             pw_en;
    logic [1:0]       pw_sel;
    logic [15:0]      pw_data;
    logic             step_en;
    logic [1:0]       step_sel;
    logic             step_dec;
    logic             ptr_en;
    logic [1:0]       ptr_sel;
    logic [15:0]      ptr_addr;
    logic             wr_lost;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cpu_regbank #(.NUM_RD(2)) uut (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data), .rd_mem(rd_mem),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_mem(wr_mem),
        .pr_sel(pr_sel), .pr_data(pr_data), .pw_en(pw_en), .pw_sel(pw_sel),
        .pw_data(pw_data), .step_en(step_en), .step_sel(step_sel), .step_dec(step_dec),
        .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_addr(ptr_addr), .wr_lost(wr_lost)
    );

    // {write code, write data, read code, expected read}
    localparam logic [21:0] VEC [10] = '{
        {3'd0, 8'h11, 3'd0, 8'h11},
        {3'd1, 8'h22, 3'd1, 8'h22},
        {3'd2, 8'h33, 3'd0, 8'h11},
        {3'd3, 8'h44, 3'd2, 8'h33},
        {3'd4, 8'h55, 3'd3, 8'h44},
        {3'd5, 8'h66, 3'd4, 8'h55},
        {3'd7, 8'h77, 3'd5, 8'h66},
        {3'd6, 8'h99, 3'd7, 8'h77},
        {3'd7, 8'h80, 3'd1, 8'h22},
        {3'd0, 8'hF0, 3'd7, 8'h80}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0;
        pw_en = 0; pw_sel = 0; pw_data = 0;
        step_en = 0; step_sel = 0; step_dec = 0;
        ptr_en = 0; ptr_sel = 0;
    endtask

    task automatic edge_go();
        @(posedge clk); #1;
        idle();
        #1;
    endtask

    task automatic rd_byte(input string req, input logic [2:0] code, input logic [7:0] exp);
        rd_sel[0] = code; rd_sel[1] = code; #1;
        chk(req, {8'h0, rd_data[0]}, {8'h0, exp});
        chk(req, {8'h0, rd_data[1]}, {8'h0, exp});
    endtask

    task automatic rd_pair(input string req, input logic [1:0] code, input logic [15:0] exp);
        pr_sel = code; #1;
        chk(req, pr_data, exp);
    endtask

    task automatic load_pair(input logic [1:0] code, input logic [15:0] v);
        pw_en = 1; pw_sel = code; pw_data = v;
        edge_go();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1; rd_sel = '0; pr_sel = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0; #1;

        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            if (k != 6) rd_byte("R1 reset byte", 3'(k), 8'h00);
        end
        for (int k = 0; k < 4; k++) rd_pair("R1 reset pair", 2'(k), 16'h0000);

        // R2/R3: table walk of byte writes and reads
        for (int i = 0; i < 10; i++) begin
            wr_en = 1; wr_sel = VEC[i][21:19]; wr_data = VEC[i][18:11];
            #1;
            chk("R3 wr_mem flag", {15'h0, wr_mem}, {15'h0, VEC[i][21:19] == 3'd6});
            edge_go();
            rd_byte("R2 byte write/read", VEC[i][10:8], VEC[i][7:0]);
        end

        // R3: code 6 read flags; nothing changed by the code 6 write
        rd_sel[0] = 3'd6; rd_sel[1] = 3'd2; #1;
        chk("R3 rd_mem port0", {15'h0, rd_mem[0]}, 16'h1);
        chk("R3 rd_mem port1", {15'h0, rd_mem[1]}, 16'h0);
        chk("R3 rd data zero", {8'h0, rd_data[0]}, 16'h0);

        // R4: pair reads
        rd_pair("R4 pair BC", 2'd0, 16'hF022);
        rd_pair("R4 pair DE", 2'd1, 16'h3344);
        rd_pair("R3 R4 pair HL", 2'd2, 16'h5566);
        rd_pair("R4 pair SP", 2'd3, 16'h0000);

        // R5: pair loads
        load_pair(2'd1, 16'hBEEF);
        rd_byte("R5 load high byte", 3'd2, 8'hBE);
        rd_byte("R5 load low byte", 3'd3, 8'hEF);
        load_pair(2'd3, 16'h1234);
        rd_pair("R5 load SP", 2'd3, 16'h1234);

        // R6: steps with carry, borrow and wrap
        load_pair(2'd3, 16'hFFFF);
        step_en = 1; step_sel = 2'd3; step_dec = 0; edge_go();
        rd_pair("R6 SP wrap up", 2'd3, 16'h0000);
        load_pair(2'd0, 16'h0000);
        step_en = 1; step_sel = 2'd0; step_dec = 1; edge_go();
        rd_byte("R6 BC borrow high", 3'd0, 8'hFF);
        rd_byte("R6 BC borrow low", 3'd1, 8'hFF);
        load_pair(2'd2, 16'h00FF);
        step_en = 1; step_sel = 2'd2; step_dec = 0; edge_go();
        rd_pair("R6 HL carry across", 2'd2, 16'h0100);

        // R7: pointer port
        load_pair(2'd2, 16'h1000);
        ptr_en = 1; ptr_sel = 2'd2; #1;
        chk("R7 inc addr pre", ptr_addr, 16'h1000);
        edge_go();
        rd_pair("R7 HL after inc", 2'd2, 16'h1001);
        ptr_en = 1; ptr_sel = 2'd3; #1;
        chk("R7 dec addr pre", ptr_addr, 16'h1001);
        edge_go();
        rd_pair("R7 HL after dec", 2'd2, 16'h1000);
        ptr_en = 1; ptr_sel = 2'd0; #1;
        chk("R7 ptr BC", ptr_addr, 16'hFFFF);
        edge_go();
        ptr_en = 1; ptr_sel = 2'd1; #1;
        chk("R7 ptr DE", ptr_addr, 16'hBEEF);
        edge_go();
        rd_pair("R7 HL untouched", 2'd2, 16'h1000);

        // R8: HL wrap
        load_pair(2'd2, 16'hFFFF);
        ptr_en = 1; ptr_sel = 2'd2; edge_go();
        rd_pair("R8 HL wrap up", 2'd2, 16'h0000);
        ptr_en = 1; ptr_sel = 2'd3; edge_go();
        rd_pair("R8 HL wrap down", 2'd2, 16'hFFFF);

        // R9: collision with byte write
        load_pair(2'd2, 16'h2000);
        ptr_en = 1; ptr_sel = 2'd2; wr_en = 1; wr_sel = 3'd4; wr_data = 8'hAA; #1;
        chk("R9 wr_lost high", {15'h0, wr_lost}, 16'h1);
        edge_go();
        rd_pair("R9 pointer wins", 2'd2, 16'h2001);
        ptr_en = 1; ptr_sel = 2'd2; wr_en = 1; wr_sel = 3'd7; wr_data = 8'h5A; #1;
        chk("R9 wr_lost low", {15'h0, wr_lost}, 16'h0);
        edge_go();
        rd_byte("R9 A written", 3'd7, 8'h5A);
        rd_pair("R9 HL stepped", 2'd2, 16'h2002);

        // R10: priority
        pw_en = 1; pw_sel = 2'd0; pw_data = 16'h1111;
        step_en = 1; step_sel = 2'd0; step_dec = 0; edge_go();
        rd_pair("R10 load over step", 2'd0, 16'h1111);
        load_pair(2'd2, 16'h4000);
        pw_en = 1; pw_sel = 2'd2; pw_data = 16'h7777; ptr_en = 1; ptr_sel = 2'd3; edge_go();
        rd_pair("R10 pointer over load", 2'd2, 16'h3FFF);
        load_pair(2'd1, 16'h0010);
        step_en = 1; step_sel = 2'd1; step_dec = 0; wr_en = 1; wr_sel = 3'd3; wr_data = 8'h99;
        edge_go();
        rd_pair("R10 step over byte", 2'd1, 16'h0011);

        // R1: reset after use
        rst = 1; @(posedge clk); #1 rst = 0; #1;
        for (int k = 0; k < 4; k++) rd_pair("R1 reset clears pairs", 2'(k), 16'h0000);
        rd_byte("R1 reset clears A", 3'd7, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule